// File: doc/BRIEF.md
# Big-Integer Multiply-Add Unit

This block is a multi-cycle execution unit that forms the unsigned sum A*B + C. A and B are 64-bit limbs, and the product is taken at its full 128-bit width. C is another 64-bit limb, zero-extended to 128 bits before it is added. The unit returns the 128-bit sum split into two halves on separate ports. The lower half is the result limb. The upper half is a 64-bit carry.

Software multiplies a long number by one 64-bit scalar one limb at a time. It feeds each upper half back as the C operand of the next limb operation. The low halves collected along the way form the limbs of the product, and the last upper half forms its most significant limb.

Operands are taken on a start pulse while the unit is idle. A radix-4 shift-add datapath then consumes two multiplier bits per cycle. When the unit finishes, it presents both halves together with a one-cycle done pulse.

Top module: `bigmac_unit`

## Requirements
- R1: While reset is held and after it is released, busy and done are 0 and both result outputs are 0.
- R2: A start pulse sampled at a clock edge while busy is 0 captures A, B and C, and busy reads 1 after that edge.
- R3: Done rises 32 clock edges after the capturing edge (64 bits / 2 bits per cycle), stays high for exactly one cycle, and busy is 0 while done is 1.
- R4: When done is 1, the low output equals bits 63:0 of A*B + C, which is (A*B + C) mod 2^64.
- R5: When done is 1, the high output equals bits 127:64 of the 128-bit sum, with C zero-extended. For example, A=1, B=1, C=all ones gives low 0 and high 1, and A=0, B=0, C=all ones gives high 0.
- R6: The sum never exceeds 128 bits. With all three operands all ones, the high output is all ones and the low output is 0.
- R7: Start pulses while busy is 1, and changes to A, B or C after the capturing edge, have no effect on the running operation or its result.
- R8: The result outputs change only at the edge where done rises, and they hold their values at all other times.
- R9: Chaining limbs of a multi-limb number X against a scalar S works as follows. Each high output is fed back as the next C, starting from C=0. The low outputs, followed by the final high output, then equal the limbs of X*S.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request a new operation; honoured only while idle |
| a_i | input | 64 | Multiplicand limb A |
| b_i | input | 64 | Multiplier limb B |
| c_i | input | 64 | Addend limb C, zero-extended |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse when results are updated |
| lo_o | output | 64 | Bits 63:0 of A*B + C |
| hi_o | output | 64 | Bits 127:64 of A*B + C (carry limb) |

## Verification
The hardest state to reach from the ports is a start request that arrives in the middle of a running operation while the operand inputs are also changing. If the datapath ever re-read its inputs, the result would be silently corrupted. The stimulus starts a known operation and, part-way through, raises start and drives unrelated operands until completion. It then compares the result with the original operands and the latency with the original capture.

Carry propagation into the upper half is forced with all-ones operands and with an all-ones addend. A four-limb chain checks that the carry limb feeds back correctly against a 320-bit reference product.

// File: rtl/bigmac_pkg.sv
// Package: shared sizing for the big-integer multiply-add unit.
// Assumes LIMB_W is a multiple of DIGIT_W.
package bigmac_pkg;
    localparam int unsigned LIMB_W  = 64;  // operand limb width
    localparam int unsigned DIGIT_W = 2;   // multiplier bits retired per cycle
endpackage

// File: rtl/bigmac_ppgen.sv
// Partial-product generator: multiplies the shifted multiplicand by one
// multiplier digit. DIGIT_W selects a radix-2, radix-4 or generic variant.
// Assumes the caller truncates the result to WW bits.
module bigmac_ppgen #(
    parameter int unsigned WW      = 128,
    parameter int unsigned DIGIT_W = 2
) (
    input  logic [WW-1:0]      mcand_i,
    input  logic [DIGIT_W-1:0] digit_i,
    output logic [WW-1:0]      pp_o
);
    generate
        if (DIGIT_W == 1) begin : g_radix2
            // Select the multiplicand or zero.
            always_comb pp_o = digit_i[0] ? mcand_i : '0;
        end else if (DIGIT_W == 2) begin : g_radix4
            // Pick 0, 1x, 2x or 3x of the multiplicand.
            always_comb begin
                case (digit_i)
                    2'd0:    pp_o = '0;
                    2'd1:    pp_o = mcand_i;
                    2'd2:    pp_o = mcand_i << 1;
                    default: pp_o = mcand_i + (mcand_i << 1);
                endcase
            end
        end else begin : g_generic
            // Sum the shifted multiplicand for each set digit bit.
            always_comb begin
                pp_o = '0;
                for (int k = 0; k < DIGIT_W; k++)
                    if (digit_i[k]) pp_o = pp_o + (mcand_i << k);
            end
        end
    endgenerate
endmodule

// File: rtl/bigmac_ctrl.sv
// Sequencer: accepts a start while idle, counts STEPS busy cycles and
// emits a one-cycle done pulse after the final step.
// Assumes STEPS >= 1.
module bigmac_ctrl #(
    parameter int unsigned STEPS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic take_o,
    output logic step_o,
    output logic last_o,
    output logic busy_o,
    output logic done_o
);
    localparam int unsigned CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;

    logic             busy_q;
    logic             done_q;
    logic [CNT_W-1:0] cnt_q;

    // Decode the handshake and the final step.
    always_comb begin
        take_o = start_i && !busy_q;
        step_o = busy_q;
        last_o = busy_q && (cnt_q == CNT_W'(STEPS - 1));
    end

    // Track busy state, step count and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            done_q <= last_o;
            if (take_o) begin
                busy_q <= 1'b1;
                cnt_q  <= '0;
            end else if (busy_q) begin
                cnt_q <= cnt_q + 1'b1;
                if (last_o) busy_q <= 1'b0;
            end
        end
    end

    assign busy_o = busy_q;
    assign done_o = done_q;
endmodule

// File: rtl/bigmac_accum.sv
// Shift-add datapath: seeds the accumulator with the zero-extended addend,
// adds one digit's partial product per step, and loads the result
// registers on the last step. Assumes LIMB_W % DIGIT_W == 0.
module bigmac_accum #(
    parameter int unsigned LIMB_W  = 64,
    parameter int unsigned DIGIT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic              step_i,
    input  logic              last_i,
    input  logic [LIMB_W-1:0] a_i,
    input  logic [LIMB_W-1:0] b_i,
    input  logic [LIMB_W-1:0] c_i,
    output logic [LIMB_W-1:0] lo_o,
    output logic [LIMB_W-1:0] hi_o
);
    localparam int unsigned WW = 2 * LIMB_W;

    logic [WW-1:0]     acc_q, mcand_q, pp, acc_nxt;
    logic [LIMB_W-1:0] mplr_q;
    logic [LIMB_W-1:0] lo_q, hi_q;

    bigmac_ppgen #(.WW(WW), .DIGIT_W(DIGIT_W)) ppgen_i (
        .mcand_i (mcand_q),
        .digit_i (mplr_q[DIGIT_W-1:0]),
        .pp_o    (pp)
    );

    // Next accumulator value for this step.
    always_comb acc_nxt = acc_q + pp;

    // Capture operands, then shift and accumulate each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            mcand_q <= '0;
            mplr_q  <= '0;
        end else if (take_i) begin
            acc_q   <= {{LIMB_W{1'b0}}, c_i};
            mcand_q <= {{LIMB_W{1'b0}}, a_i};
            mplr_q  <= b_i;
        end else if (step_i) begin
            acc_q   <= acc_nxt;
            mcand_q <= mcand_q << DIGIT_W;
            mplr_q  <= mplr_q >> DIGIT_W;
        end
    end

    // Load both result halves together on the final step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (last_i) begin
            lo_q <= acc_nxt[LIMB_W-1:0];
            hi_q <= acc_nxt[WW-1:LIMB_W];
        end
    end

    assign lo_o = lo_q;
    assign hi_o = hi_q;
endmodule

// File: rtl/bigmac_unit.sv
// Top: unsigned LIMB_W x LIMB_W + LIMB_W multiply-add returning both halves
// of the double-width sum. Start is honoured only while idle; results are
// held until the next completion.
module bigmac_unit #(
    parameter int unsigned LIMB_W  = bigmac_pkg::LIMB_W,
    parameter int unsigned DIGIT_W = bigmac_pkg::DIGIT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [LIMB_W-1:0] a_i,
    input  logic [LIMB_W-1:0] b_i,
    input  logic [LIMB_W-1:0] c_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [LIMB_W-1:0] lo_o,
    output logic [LIMB_W-1:0] hi_o
);
    localparam int unsigned STEPS = LIMB_W / DIGIT_W;

    logic take, step, last;

    bigmac_ctrl #(.STEPS(STEPS)) ctrl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .take_o  (take),
        .step_o  (step),
        .last_o  (last),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    bigmac_accum #(.LIMB_W(LIMB_W), .DIGIT_W(DIGIT_W)) accum_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .take_i (take),
        .step_i (step),
        .last_i (last),
        .a_i    (a_i),
        .b_i    (b_i),
        .c_i    (c_i),
        .lo_o   (lo_o),
        .hi_o   (hi_o)
    );
endmodule

// File: rtl/bigmac_unit_chk.sv
// Checker: port-level properties of the multiply-add unit, bound to the top.
// Keeps its own latency counter so the window does not depend on $past depth.
module bigmac_unit_chk #(
    parameter int unsigned LIMB_W  = 64,
    parameter int unsigned DIGIT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [LIMB_W-1:0] lo_o,
    input logic [LIMB_W-1:0] hi_o
);
    localparam int unsigned STEPS = LIMB_W / DIGIT_W;
    localparam int unsigned LAT_W = $clog2(STEPS + 1) + 1;

    logic [LAT_W-1:0] lat_q;

    // Count edges from the capturing edge while the unit is busy.
    always_ff @(posedge clk) begin
        if (!rst_n) lat_q <= '0;
        else if (start_i && !busy_o) lat_q <= '0;
        else if (busy_o) lat_q <= lat_q + 1'b1;
    end

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!busy_o && !done_o && lo_o == '0 && hi_o == '0)); // R1
    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o); // R2
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R3
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R3
    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (lat_q == LAT_W'(STEPS))); // R3
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(lo_o) && $stable(hi_o))); // R8
endmodule

bind bigmac_unit bigmac_unit_chk #(.LIMB_W(LIMB_W), .DIGIT_W(DIGIT_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .lo_o    (lo_o),
    .hi_o    (hi_o)
);

// File: tb/bigmac_unit_tb_top.sv
// Directed bench for bigmac_unit: one task per scenario, each self-checking.
module bigmac_unit_tb_top;
    localparam int W   = 64;
    localparam int LAT = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [W-1:0] a_i = '0, b_i = '0, c_i = '0;
    logic         busy_o, done_o;
    logic [W-1:0] lo_o, hi_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;  // 250 MHz

    bigmac_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .a_i(a_i), .b_i(b_i), .c_i(c_i),
        .busy_o(busy_o), .done_o(done_o), .lo_o(lo_o), .hi_o(hi_o)
    );

    task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Launch one operation and wait for done; returns measured latency.
    task automatic launch(input logic [W-1:0] a, input logic [W-1:0] b,
                          input logic [W-1:0] c, output int lat);
        @(negedge clk);
        a_i = a; b_i = b; c_i = c; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o === 1'b1, "R2 busy after start", W'(busy_o), W'(1));
        lat = 0;
        while (done_o !== 1'b1 && lat < 100) begin
            @(negedge clk);
            lat++;
        end
    endtask

    // Run one op and compare both halves and the latency with the reference.
    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                          input logic [W-1:0] c);
        logic [2*W-1:0] e;
        int lat;
        e = {{W{1'b0}}, a} * {{W{1'b0}}, b} + {{W{1'b0}}, c};
        launch(a, b, c, lat);
        check(lat == LAT, "R3 latency", W'(lat), W'(LAT));
        check(busy_o === 1'b0, "R3 busy low with done", W'(busy_o), W'(0));
        check(lo_o === e[W-1:0], "R4 low half", lo_o, e[W-1:0]);
        check(hi_o === e[2*W-1:W], "R5 high half", hi_o, e[2*W-1:W]);
        @(negedge clk);
        check(done_o === 1'b0, "R3 done one cycle", W'(done_o), W'(0));
    endtask

    task automatic t_reset();
        check(busy_o === 1'b0 && done_o === 1'b0, "R1 flags in reset",
              W'({busy_o, done_o}), W'(0));
        check(lo_o === '0 && hi_o === '0, "R1 results in reset", lo_o | hi_o, '0);
    endtask

    task automatic t_corners();
        run_op('0, '0, '0);
        run_op('0, '0, '1);                 // R5 zero-extension: high stays 0
        check(hi_o === '0, "R5 addend not sign-extended", hi_o, '0);
        run_op(64'd1, 64'd1, '1);           // R5 carry into high half
        check(hi_o === 64'd1 && lo_o === '0, "R5 addend carry", hi_o, 64'd1);
        run_op('1, '1, '1);                 // R6 largest sum fits 128 bits
        check(hi_o === '1 && lo_o === '0, "R6 max operands", hi_o, '1);
        run_op(64'hDEAD_BEEF_0123_4567, 64'd3, 64'd5);
        run_op(64'h8000_0000_0000_0000, 64'h2, 64'h0);
    endtask

    task automatic t_random();
        logic [W-1:0] s = 64'h9E37_79B9_7F4A_7C15;
        logic [W-1:0] v [3];
        for (int n = 0; n < 12; n++) begin
            for (int k = 0; k < 3; k++) begin
                s = s ^ (s << 13); s = s ^ (s >> 7); s = s ^ (s << 17);
                v[k] = s;
            end
            run_op(v[0], v[1], v[2]);       // R4 R5 assorted patterns
        end
    endtask

    // R7: start and operand changes while busy are ignored.
    task automatic t_busy_ignore();
        logic [2*W-1:0] e;
        int lat;
        e = {64'b0, 64'h0123_4567_89AB_CDEF} * {64'b0, 64'hFEDC_BA98_7654_3210}
            + {64'b0, 64'h1111_2222_3333_4444};
        @(negedge clk);
        a_i = 64'h0123_4567_89AB_CDEF; b_i = 64'hFEDC_BA98_7654_3210;
        c_i = 64'h1111_2222_3333_4444; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 0;
        for (int k = 0; k < 10; k++) begin @(negedge clk); lat++; end
        a_i = '1; b_i = 64'd7; c_i = 64'd9; start_i = 1'b1;
        @(negedge clk); lat++;
        start_i = 1'b0;
        while (done_o !== 1'b1 && lat < 100) begin @(negedge clk); lat++; end
        check(lat == LAT, "R7 latency unchanged", W'(lat), W'(LAT));
        check(lo_o === e[W-1:0], "R7 low unaffected", lo_o, e[W-1:0]);
        check(hi_o === e[2*W-1:W], "R7 high unaffected", hi_o, e[2*W-1:W]);
        @(negedge clk);
        check(busy_o === 1'b0, "R7 no second operation", W'(busy_o), W'(0));
    endtask

    // R8: outputs hold between completions.
    task automatic t_hold();
        logic [W-1:0] l0, h0;
        l0 = lo_o; h0 = hi_o;
        a_i = 64'h5555; b_i = 64'hAAAA; c_i = 64'h1234;
        for (int k = 0; k < 6; k++) @(negedge clk);
        check(lo_o === l0, "R8 low held", lo_o, l0);
        check(hi_o === h0, "R8 high held", hi_o, h0);
    endtask

    // R9: four-limb chain against a 320-bit reference product.
    task automatic t_chain();
        logic [4*W-1:0] x = 256'hF00D_CAFE_1234_5678_9ABC_DEF0_0FED_CBA9_8765_4321_FFFF_FFFF_FFFF_FFFF_0000_0001;
        logic [W-1:0]   sc = 64'hFFFF_FFFF_0000_0007;
        logic [5*W-1:0] refp, got;
        logic [W-1:0]   carry = '0;
        int lat;
        refp = {{W{1'b0}}, x} * {{4*W{1'b0}}, sc};
        got = '0;
        for (int i = 0; i < 4; i++) begin
            launch(x[i*W +: W], sc, carry, lat);
            got[i*W +: W] = lo_o;
            carry = hi_o;
        end
        got[4*W +: W] = carry;
        for (int i = 0; i < 5; i++)
            check(got[i*W +: W] === refp[i*W +: W], "R9 chained limb",
                  got[i*W +: W], refp[i*W +: W]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_corners();
        t_random();
        t_busy_ignore();
        t_hold();
        t_chain();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule